// File: doc/BRIEF.md
# Capacitive Touch Charge-Transfer Sequencer

This block runs one charge-transfer burst over as many as eight sensing groups at once. On a start request it latches which groups must deliver a result. It clears a shared pulse counter and holds every enabled electrode and sampling capacitor in discharge for a programmable number of cycles. It then issues one charge-transfer strobe for each pulse tick it is given. Each group's sampling node feeds a comparator. When that comparator input goes high, the group stores the shared pulse count as its result and is then masked against later events.

The burst ends in one of two ways. It ends normally when every group that owes a result has captured one. It ends by timeout when the counter reaches the programmed maximum plus one, and every group still waiting then stores that count. Either way the block spends one cycle in discharge again, drops busy and pulses done. Groups marked burst-only are charged along with the others but never write a result. If no group owes a result, a start only produces done. The analog switches, the pulse timebase and the pin routing belong to the surrounding logic.

Top module: `ctsense_seq`

## Requirements
- R1: The group count is a parameter (default 8). Bit i of every group mask belongs to group i, and group i's result sits at `resultFlat[16*i +: 16]` with the default counter width.
- R2: The groups that owe a result are `enableMask & ~burstOnlyMask`, latched at start. A burst-only group shares the charge strobes, but its result keeps its previous value.
- R3: A start whose completion set is empty raises done for exactly one cycle, starting the cycle after the start. Busy stays low and no charge strobe or discharge is issued.
- R4: An accepted start clears the pulse counter and holds `dischargeOn` high for `dischargeDelay + 1` cycles before any charge strobe. `dischargeOn` is high again for one cycle at the end of the burst.
- R5: Comparator inputs pass through a two-flop synchronizer. While pulsing, any synchronized input that is high on a group that owes a result and has not captured starts a capture cycle. In that cycle every such group stores the count, and those groups then ignore their inputs until the next start.
- R6: When every owed group has captured, the next cycle is the end-of-burst discharge cycle. After it busy falls and done is high for one cycle.
- R7: When the count equals `maxCount + 1`, pulsing stops. Every owed group that has not captured stores `maxCount + 1`, and the burst ends as in R6.
- R8: No charge strobe is issued and the count is held during a capture cycle. `chargePulse` is high only while pulsing, on a `pulseTick`, and each strobe raises the count by one.
- R9: A start request while busy has no effect. Results change only by capture or timeout, so they hold between bursts.
- R10: After reset busy, done, `dischargeOn` and `chargePulse` are low and all results are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Request a burst (one cycle) |
| enableMask | input | 8 | Groups whose sampling channel is enabled |
| burstOnlyMask | input | 8 | Groups charged but never measured |
| cmpIn | input | 8 | Raw sampling-node comparator inputs |
| pulseTick | input | 1 | Permission to issue one charge-transfer pulse |
| maxCount | input | 16 | Timeout limit; timeout at this value plus one |
| dischargeDelay | input | 8 | Extra discharge cycles after start |
| dischargeOn | output | 1 | Hold all enabled capacitors in discharge |
| chargePulse | output | 1 | One charge-transfer strobe |
| resultFlat | output | 128 | Per-group captured counts, 16 bits each |
| busy | output | 1 | Burst in progress |
| done | output | 1 | One-cycle end-of-burst pulse |

## Verification
The bench builds the block with its defaults: eight groups, a 16-bit counter and an 8-bit discharge delay. This lets every group take part in one burst, with simultaneous captures, burst-only and disabled groups all in the same run. Each run drives small `maxCount` values (20 and 200) and short delays (0 to 3). This puts the timeout path and the zero-delay discharge corner within a few hundred cycles, and pulse ticks every one, two or three cycles vary how far the count moves past each threshold across the synchronizer latency.

// File: rtl/ctsense_pkg.sv
package ctsense_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_DISCH = 3'd1,
    ST_PULSE = 3'd2,
    ST_CAPT  = 3'd3,
    ST_FIN   = 3'd4
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadStart;
    logic decDelay;
    logic incCount;
    logic capture;
    logic timeoutFill;
    logic clearFinished;
  } dpCtrl_t;

  // status from datapath to control
  typedef struct packed {
    logic emptyStart;
    logic delayZero;
    logic atLimit;
    logic eventPending;
    logic captureCompletes;
  } dpStat_t;

endpackage

// File: rtl/ctsense_sync.sv
module ctsense_sync #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stage1;
  logic [WIDTH-1:0] stage2;

  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rstN) begin
        stage1[g] <= 1'b0;
        stage2[g] <= 1'b0;
      end else begin
        stage1[g] <= asyncIn[g];
        stage2[g] <= stage1[g];
      end
    end
  end

  assign syncOut = stage2;
endmodule

// File: rtl/ctsense_datapath.sv
module ctsense_datapath
  import ctsense_pkg::*;
#(
  parameter int NUM_GROUPS = 8,
  parameter int CNT_W      = 16,
  parameter int DLY_W      = 8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  dpCtrl_t                     ctrl,
  input  logic [NUM_GROUPS-1:0]       enableMask,
  input  logic [NUM_GROUPS-1:0]       burstOnlyMask,
  input  logic [NUM_GROUPS-1:0]       cmpSync,
  input  logic [CNT_W-1:0]            maxCount,
  input  logic [DLY_W-1:0]            dischargeDelay,
  output dpStat_t                     stat,
  output logic [NUM_GROUPS*CNT_W-1:0] resultFlat
);
  localparam int LIM_W = CNT_W + 1;

  logic [NUM_GROUPS-1:0] compMask;
  logic [NUM_GROUPS-1:0] finished;
  logic [NUM_GROUPS-1:0] capMask;
  logic [NUM_GROUPS-1:0] pendMask;
  logic [LIM_W-1:0]      count;
  logic [LIM_W-1:0]      limit;
  logic [DLY_W-1:0]      delayCnt;
  logic [CNT_W-1:0]      resReg [NUM_GROUPS];

  assign pendMask = compMask & ~finished;
  assign capMask  = pendMask & cmpSync;

  assign stat.emptyStart       = ((enableMask & ~burstOnlyMask) == '0);
  assign stat.delayZero        = (delayCnt == '0);
  assign stat.atLimit          = (count == limit);
  assign stat.eventPending     = (capMask != '0);
  assign stat.captureCompletes = ((finished | capMask) == compMask);

  // burst-wide state
  always_ff @(posedge clk) begin
    if (!rstN) begin
      compMask <= '0;
      finished <= '0;
      count    <= '0;
      limit    <= '0;
      delayCnt <= '0;
    end else begin
      if (ctrl.loadStart) begin
        compMask <= enableMask & ~burstOnlyMask;
        finished <= '0;
        count    <= '0;
        limit    <= LIM_W'(maxCount) + LIM_W'(1);
        delayCnt <= dischargeDelay;
      end else begin
        if (ctrl.decDelay)
          delayCnt <= delayCnt - DLY_W'(1);
        if (ctrl.incCount)
          count <= count + LIM_W'(1);
        if (ctrl.capture)
          finished <= finished | capMask;
        else if (ctrl.clearFinished)
          finished <= '0;
      end
    end
  end

  // per-group result registers
  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_res
    always_ff @(posedge clk) begin
      if (!rstN)
        resReg[g] <= '0;
      else if ((ctrl.capture && capMask[g]) || (ctrl.timeoutFill && pendMask[g]))
        resReg[g] <= count[CNT_W-1:0];
    end
    assign resultFlat[g*CNT_W +: CNT_W] = resReg[g];
  end

  // R5: only owed groups can be marked captured
  a_r5_finished_in_comp: assert property (@(posedge clk) disable iff (!rstN)
    (finished & ~compMask) == '0);

  // R7: the counter never runs past the timeout compare value
  a_r7_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    count <= limit);

  // R9: results move only on a capture or timeout strobe
  a_r9_results_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(ctrl.capture || ctrl.timeoutFill) |=> $stable(resultFlat));

  // R8: a capture cycle does not advance the count
  a_r8_capture_holds_count: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.capture |=> $stable(count));
endmodule

// File: rtl/ctsense_control.sv
module ctsense_control
  import ctsense_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    startReq,
  input  logic    pulseTick,
  input  dpStat_t stat,
  output dpCtrl_t ctrl,
  output logic    dischargeOn,
  output logic    chargePulse,
  output logic    busy,
  output logic    done
);
  seqState_t state;
  seqState_t stateNext;
  logic      emptyHit;
  logic      doneQ;

  always_comb begin
    stateNext   = state;
    ctrl        = '0;
    emptyHit    = 1'b0;
    dischargeOn = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (startReq) begin
          if (stat.emptyStart) begin
            emptyHit = 1'b1;
          end else begin
            ctrl.loadStart = 1'b1;
            stateNext      = ST_DISCH;
          end
        end
      end
      ST_DISCH: begin
        dischargeOn = 1'b1;
        if (stat.delayZero) stateNext = ST_PULSE;
        else                ctrl.decDelay = 1'b1;
      end
      ST_PULSE: begin
        if (stat.atLimit) begin
          ctrl.timeoutFill = 1'b1;
          stateNext        = ST_FIN;
        end else if (stat.eventPending) begin
          stateNext = ST_CAPT;
        end else if (pulseTick) begin
          ctrl.incCount = 1'b1;
        end
      end
      ST_CAPT: begin
        ctrl.capture = 1'b1;
        stateNext    = stat.captureCompletes ? ST_FIN : ST_PULSE;
      end
      ST_FIN: begin
        dischargeOn        = 1'b1;
        ctrl.clearFinished = 1'b1;
        stateNext          = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      doneQ <= 1'b0;
    end else begin
      state <= stateNext;
      doneQ <= (state == ST_FIN) || emptyHit;
    end
  end

  assign chargePulse = ctrl.incCount;
  assign busy        = (state != ST_IDLE);
  assign done        = doneQ;

  // R6: the end-of-burst discharge cycle is followed by done and idle
  a_r6_finish_then_done: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_FIN) |=> (done && !busy));

  // R3: an empty start reports done without becoming busy
  a_r3_empty_start: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && startReq && stat.emptyStart) |=> (done && !busy && !dischargeOn));

  // R9: a start request while busy never restarts the discharge phase
  a_r9_busy_start_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (busy && state != ST_FIN) |=> busy);

  // R6: done is a single-cycle pulse
  a_r6_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done || $past(emptyHit));
endmodule

// File: rtl/ctsense_seq.sv
module ctsense_seq
  import ctsense_pkg::*;
#(
  parameter int NUM_GROUPS = 8,
  parameter int CNT_W      = 16,
  parameter int DLY_W      = 8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        startReq,
  input  logic [NUM_GROUPS-1:0]       enableMask,
  input  logic [NUM_GROUPS-1:0]       burstOnlyMask,
  input  logic [NUM_GROUPS-1:0]       cmpIn,
  input  logic                        pulseTick,
  input  logic [CNT_W-1:0]            maxCount,
  input  logic [DLY_W-1:0]            dischargeDelay,
  output logic                        dischargeOn,
  output logic                        chargePulse,
  output logic [NUM_GROUPS*CNT_W-1:0] resultFlat,
  output logic                        busy,
  output logic                        done
);
  logic [NUM_GROUPS-1:0] cmpSync;
  dpCtrl_t               ctrl;
  dpStat_t               stat;

  ctsense_sync #(.WIDTH(NUM_GROUPS)) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn (cmpIn),
    .syncOut (cmpSync)
  );

  ctsense_datapath #(
    .NUM_GROUPS (NUM_GROUPS),
    .CNT_W      (CNT_W),
    .DLY_W      (DLY_W)
  ) u_dp (
    .clk            (clk),
    .rstN           (rstN),
    .ctrl           (ctrl),
    .enableMask     (enableMask),
    .burstOnlyMask  (burstOnlyMask),
    .cmpSync        (cmpSync),
    .maxCount       (maxCount),
    .dischargeDelay (dischargeDelay),
    .stat           (stat),
    .resultFlat     (resultFlat)
  );

  ctsense_control u_ctl (
    .clk         (clk),
    .rstN        (rstN),
    .startReq    (startReq),
    .pulseTick   (pulseTick),
    .stat        (stat),
    .ctrl        (ctrl),
    .dischargeOn (dischargeOn),
    .chargePulse (chargePulse),
    .busy        (busy),
    .done        (done)
  );
endmodule

// File: tb/sim_ctsense_seq.sv
`timescale 1ns/1ps
module sim_ctsense_seq;
  localparam int G  = 8;
  localparam int CW = 16;
  localparam int PH_IDLE = 0, PH_DIS = 1, PH_PUL = 2, PH_CAP = 3, PH_FIN = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          startReq = 1'b0;
  logic [G-1:0]  enableMask = '0;
  logic [G-1:0]  burstOnlyMask = '0;
  logic [G-1:0]  cmpIn = '0;
  logic          pulseTick = 1'b0;
  logic [CW-1:0] maxCount = '0;
  logic [7:0]    dischargeDelay = '0;
  logic          dischargeOn, chargePulse, busy, done;
  logic [G*CW-1:0] resultFlat;

  int nChecks = 0;
  int nFails  = 0;
  int cyc     = 0;
  int thr [G];
  int tickPer = 1;

  always #4 clk = ~clk;

  ctsense_seq u0 (
    .clk(clk), .rstN(rstN), .startReq(startReq), .enableMask(enableMask),
    .burstOnlyMask(burstOnlyMask), .cmpIn(cmpIn), .pulseTick(pulseTick),
    .maxCount(maxCount), .dischargeDelay(dischargeDelay),
    .dischargeOn(dischargeOn), .chargePulse(chargePulse),
    .resultFlat(resultFlat), .busy(busy), .done(done)
  );

  // ---------------- behavioural reference model ----------------
  int          mPhase;
  int          mCnt, mLim, mDly, mPulses;
  logic [G-1:0] mComp, mFin, s1, s2, ev;
  logic [CW-1:0] mRes [G];
  logic        mDone, newDone, pulseNow;

  function automatic logic predPulse();
    logic [G-1:0] e;
    e = s2 & mComp & ~mFin;
    return (mPhase == PH_PUL) && pulseTick && (mCnt != mLim) && (e == '0);
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mPhase = PH_IDLE; mCnt = 0; mLim = 0; mDly = 0; mPulses = 0;
      mComp = '0; mFin = '0; s1 = '0; s2 = '0; mDone = 1'b0;
      for (int i = 0; i < G; i++) mRes[i] = '0;
    end else begin
      ev = s2 & mComp & ~mFin;
      pulseNow = predPulse();
      newDone = 1'b0;
      case (mPhase)
        PH_IDLE: if (startReq) begin
          if ((enableMask & ~burstOnlyMask) == '0) newDone = 1'b1;
          else begin
            mPhase = PH_DIS; mComp = enableMask & ~burstOnlyMask; mFin = '0;
            mCnt = 0; mLim = int'(maxCount) + 1; mDly = int'(dischargeDelay);
            mPulses = 0;
          end
        end
        PH_DIS: if (mDly == 0) mPhase = PH_PUL; else mDly--;
        PH_PUL: begin
          if (mCnt == mLim) begin
            for (int i = 0; i < G; i++)
              if (mComp[i] && !mFin[i]) mRes[i] = CW'(mCnt);
            mPhase = PH_FIN;
          end else if (ev != '0) mPhase = PH_CAP;
          else if (pulseNow) begin mCnt++; mPulses++; end
        end
        PH_CAP: begin
          for (int i = 0; i < G; i++)
            if (ev[i]) begin mRes[i] = CW'(mCnt); mFin[i] = 1'b1; end
          mPhase = (mFin == mComp) ? PH_FIN : PH_PUL;
        end
        default: begin mFin = '0; mPhase = PH_IDLE; newDone = 1'b1; end
      endcase
      s2 = s1; s1 = cmpIn;
      mDone = newDone;
    end
  end

  // ---------------- checking ----------------
  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s at cycle %0d: actual=%0d expected=%0d", tag, what, cyc, act, exp);
    end
  endtask

  function automatic logic [CW-1:0] resOf(input int i);
    return resultFlat[i*CW +: CW];
  endfunction

  task automatic compareAll();
    chk("R4", "dischargeOn", dischargeOn, (mPhase == PH_DIS) || (mPhase == PH_FIN));
    chk("R8", "chargePulse", chargePulse, predPulse());
    chk("R6", "busy", busy, mPhase != PH_IDLE);
    chk("R6", "done", done, mDone);
    for (int i = 0; i < G; i++) chk("R5", $sformatf("result[%0d]", i), resOf(i), mRes[i]);
  endtask

  // one cycle: compare at the falling edge, then drive the next inputs
  task automatic step(input logic st);
    @(negedge clk);
    cyc++;
    compareAll();
    startReq  = st;
    pulseTick = ((cyc % tickPer) == 0);
    for (int i = 0; i < G; i++)
      cmpIn[i] = ((mPhase == PH_PUL) || (mPhase == PH_CAP)) && (mPulses >= thr[i]);
  endtask

  int disCycles;
  task automatic runAcq(input logic [G-1:0] en, input logic [G-1:0] bo, input int lim,
                        input int dly, input int per, input bit injectBusyStart);
    int n;
    tickPer = per;
    @(negedge clk);
    enableMask = en; burstOnlyMask = bo; maxCount = CW'(lim); dischargeDelay = 8'(dly);
    step(1'b1);
    disCycles = 0; n = 0;
    do begin
      n++;
      if (injectBusyStart && n == 20) begin
        enableMask = '0;   // would be an empty start if honoured (R9)
        step(1'b1);
        enableMask = en;
      end else step(1'b0);
      if (dischargeOn) disCycles++;
    end while (!done && n < 5000);
    chk("R6", "burst ended with done", done, 1);
    chk("R4", "dischargeOn cycles (start + end)", disCycles, dly + 2);
    step(1'b0);
    chk("R6", "done lasts one cycle", done, 0);
  endtask

  logic [CW-1:0] saved [G];

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL all requirements: watchdog expired actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin : stim
    for (int i = 0; i < G; i++) thr[i] = 1000;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 / R10: reset state
    chk("R10", "busy after reset", busy, 0);
    chk("R10", "done after reset", done, 0);
    chk("R10", "dischargeOn after reset", dischargeOn, 0);
    for (int i = 0; i < G; i++) chk("R1", $sformatf("R10 result[%0d] reset", i), resOf(i), 0);

    // run A: all groups, distinct thresholds, a start injected while busy
    thr = '{5, 9, 13, 17, 21, 25, 29, 33};
    runAcq(8'hFF, 8'h00, 200, 3, 1, 1'b1);
    chk("R5", "group0 captured near its threshold", (resOf(0) >= 5 && resOf(0) <= 8), 1);
    for (int i = 0; i < G; i++) saved[i] = resOf(i);

    // run B: burst-only groups 0 and 2, disabled 6 and 7, ties on 1 and 3, zero delay
    thr = '{4, 6, 7, 6, 10, 40, 2, 2};
    runAcq(8'h3F, 8'h05, 200, 0, 3, 1'b0);
    chk("R2", "burst-only group0 result kept", resOf(0), saved[0]);
    chk("R2", "burst-only group2 result kept", resOf(2), saved[2]);
    chk("R5", "disabled group7 result kept", resOf(7), saved[7]);
    chk("R5", "tied groups 1 and 3 capture together", resOf(1), resOf(3));

    // run C: timeout with groups 2, 4, 5 never crossing
    thr = '{3, 8, 1000, 15, 1000, 1000, 2, 19};
    runAcq(8'hFF, 8'h00, 20, 2, 2, 1'b0);
    chk("R7", "group2 timed out at maxCount+1", resOf(2), 21);
    chk("R7", "group4 timed out at maxCount+1", resOf(4), 21);
    chk("R7", "group5 timed out at maxCount+1", resOf(5), 21);
    for (int i = 0; i < G; i++) saved[i] = resOf(i);

    // run D: empty completion set
    @(negedge clk);
    enableMask = 8'h30; burstOnlyMask = 8'h30;
    step(1'b1);
    step(1'b0);
    chk("R3", "empty start: done", done, 1);
    chk("R3", "empty start: busy", busy, 0);
    chk("R3", "empty start: no charge pulse", chargePulse, 0);
    step(1'b0);
    chk("R3", "empty start: done one cycle", done, 0);

    // R9: results stay put while idle
    repeat (10) step(1'b0);
    for (int i = 0; i < G; i++) chk("R9", $sformatf("result[%0d] held", i), resOf(i), saved[i]);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule